// File: doc/BRIEF.md
# Loadable Up/Down Position Counter

This block holds the digital angle word of a tracking angle converter. The loop beside it reports the sense of rotation on `rot_up` and issues one step request for each least-significant-bit of movement. Each accepted step moves the count by one in the sense that `rot_up` gives when the step is accepted. The count wraps modulo 2^N, and a one-cycle `ripple` pulse marks each pass through zero. The registered direction output always settles at least one cycle before the `busy`, data and `ripple` changes that belong to the same step. This lets a downstream reader latch the sense first and then the data.

Steps arrive on a valid/ready pair. A step is taken on a rising edge where `step_valid` and `step_ready` are both high. `step_ready` is low in any cycle where `load_req` is high. A producer facing back-pressure holds `step_valid` and its direction until the step is taken. A parallel load either writes `load_word` into the count or, with the active-low `clr_sel_n` low, clears only the count bits where `load_word` has a one. The count is shown on a tri-state bus that is driven only while `oe_n` is low.

Top module: `track_pos_counter`

## Requirements
- R1: While reset is asserted, the count is 0, `dir_out` is 1 (up), and `busy` and `ripple` are 0.
- R2: `dir_out` takes the value of `rot_up` one clock after each edge, including when `rot_up` toggles with no step. Such toggles leave the count unchanged.
- R3: A step taken at edge E changes the count by +1 if `rot_up` was 1 at E, or by -1 if it was 0. The new count appears after edge E+1, and `busy` is high for exactly that one cycle.
- R4: For a step taken at edge E, `dir_out` shows that step's direction after E. This is one cycle before `busy` and the new count appear.
- R5: The count wraps modulo 2^N. `ripple` is 1 in the same cycle as `busy` when a step goes from all ones to 0 (up) or from 0 to all ones (down). Otherwise `ripple` is 0.
- R6: A load at edge E with `clr_sel_n` = 1 sets the count to `load_word` after E, and `busy` stays 0.
- R7: A load at edge E with `clr_sel_n` = 0 sets each count bit to 0 where `load_word` has a 1, and keeps every other bit. The result appears after E, and `busy` stays 0.
- R8: A load takes priority over steps. `step_ready` is 0 while `load_req` is 1. A step taken on the edge just before a load edge is dropped: the count equals the load result, and `busy` stays 0.
- R9: `pos_bus` carries the count while `oe_n` is 0, and every bit of it is high-impedance while `oe_n` is 1.
- R10: Steps taken on consecutive edges are each counted, and `busy` stays high for one cycle per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rot_up | input | 1 | Rotation sense from the loop: 1 means up |
| step_valid | input | 1 | Step request, valid |
| step_ready | output | 1 | Step accepted when high together with step_valid |
| load_req | input | 1 | Parallel load strobe, active high |
| clr_sel_n | input | 1 | Active-low complement: selective clear instead of overwrite |
| load_word | input | CNT_W | Parallel load data |
| oe_n | input | 1 | Bus output enable, active low |
| pos_bus | output | CNT_W | Tri-state count bus |
| dir_out | output | 1 | Registered direction |
| busy | output | 1 | One-cycle pulse per counted step |
| ripple | output | 1 | One-cycle wrap pulse |

## Verification
After a step is taken at an edge, `dir_out` is due in the cycle after that edge, and `busy`, the new count and `ripple` are due one cycle later. The bench therefore checks direction and the unchanged count at the first falling edge, step results at the second falling edge, and the return of `busy` to 0 at the third. Load results are due right after the load edge and are checked at the next falling edge. Bus float is checked a fraction of a cycle after `oe_n` changes, since the bus path has no register. A 4-bit build is swept over every start value in both directions, and over every pair of count and mask for the selective clear.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {
    SENSE_DOWN = 1'b0,
    SENSE_UP   = 1'b1
  } sense_e;
endpackage

// File: rtl/tpc_step_stage.sv
module tpc_step_stage
  import tpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_valid,
  input  logic rot_up,
  input  logic load_req,
  output logic step_ready,
  output logic go,
  output logic go_up,
  output logic dir_out
);
  sense_e dir_q;
  sense_e pend_sense;
  logic   pend_q;
  logic   take;

  // load owns the cycle; steps wait (R8)
  assign step_ready = !load_req;
  assign take       = step_valid && step_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= SENSE_UP;
      pend_sense <= SENSE_UP;
      pend_q     <= 1'b0;
    end else begin
      dir_q  <= rot_up ? SENSE_UP : SENSE_DOWN;
      pend_q <= take;
      if (take) pend_sense <= rot_up ? SENSE_UP : SENSE_DOWN;
    end
  end

  assign go      = pend_q;
  assign go_up   = (pend_sense == SENSE_UP);
  assign dir_out = (dir_q == SENSE_UP);

  a_r4_pend_matches_dir: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (go_up == dir_out));
  a_r10_take_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_ready) |=> go);
endmodule

// File: rtl/tpc_count_core.sv
module tpc_count_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_up,
  input  logic             load_req,
  input  logic             clr_sel_n,
  input  logic [CNT_W-1:0] load_word,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             ripple
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             busy_q, rip_q, stepped, wrap;

  always_comb begin
    nxt     = cnt_q;
    stepped = 1'b0;
    wrap    = 1'b0;
    if (load_req) begin
      nxt = clr_sel_n ? load_word : (cnt_q & ~load_word);
    end else if (go) begin
      stepped = 1'b1;
      if (go_up) begin
        nxt  = cnt_q + ONE;
        wrap = &cnt_q;
      end else begin
        nxt  = cnt_q - ONE;
        wrap = ~|cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rip_q  <= 1'b0;
    end else begin
      cnt_q  <= nxt;
      busy_q <= stepped;
      rip_q  <= wrap;
    end
  end

  assign count  = cnt_q;
  assign busy   = busy_q;
  assign ripple = rip_q;

  a_r6_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && clr_sel_n) |=> (count == $past(load_word)));
  a_r7_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !clr_sel_n) |=> (count == ($past(count) & ~$past(load_word))));
  a_r8_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !busy);
  a_r5_ripple_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ripple |-> busy);
  a_r3_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((count == $past(count) + ONE) || (count == $past(count) - ONE)));
endmodule

// File: rtl/tpc_bus_drive.sv
module tpc_bus_drive #(
  parameter int CNT_W = 12
) (
  input  logic             oe_n,
  input  logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] bus
);
  assign bus = oe_n ? {CNT_W{1'bz}} : value;
endmodule

// File: rtl/track_pos_counter.sv
module track_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rot_up,
  input  logic             step_valid,
  output logic             step_ready,
  input  logic             load_req,
  input  logic             clr_sel_n,
  input  logic [CNT_W-1:0] load_word,
  input  logic             oe_n,
  output logic [CNT_W-1:0] pos_bus,
  output logic             dir_out,
  output logic             busy,
  output logic             ripple
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             go, go_up;
  logic [CNT_W-1:0] count;

  tpc_step_stage u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .rot_up     (rot_up),
    .load_req   (load_req),
    .step_ready (step_ready),
    .go         (go),
    .go_up      (go_up),
    .dir_out    (dir_out)
  );

  tpc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_up     (go_up),
    .load_req  (load_req),
    .clr_sel_n (clr_sel_n),
    .load_word (load_word),
    .count     (count),
    .busy      (busy),
    .ripple    (ripple)
  );

  tpc_bus_drive #(.CNT_W(CNT_W)) u_bus (
    .oe_n  (oe_n),
    .value (count),
    .bus   (pos_bus)
  );

  // direction register leads the step result by one cycle (R4)
  a_r4_dir_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count == ($past(dir_out) ? $past(count) + ONE : $past(count) - ONE)));
  a_r5_wrap_up_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ripple && $past(dir_out)) |-> (count == '0));
endmodule

// File: tb/track_pos_counter_test.sv
`timescale 1ns/1ps
module track_pos_counter_test;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n, rot_up, step_valid, load_req, clr_sel_n, oe_n;
  logic [W-1:0] load_word;
  wire  [W-1:0] pos_bus;
  logic         step_ready, dir_out, busy, ripple;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  track_pos_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rot_up(rot_up), .step_valid(step_valid),
    .step_ready(step_ready), .load_req(load_req), .clr_sel_n(clr_sel_n),
    .load_word(load_word), .oe_n(oe_n), .pos_bus(pos_bus),
    .dir_out(dir_out), .busy(busy), .ripple(ripple)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic do_load(input int word, input bit comp, input int exp, input string req);
    @(negedge clk);
    load_req = 1'b1; load_word = W'(word); clr_sel_n = !comp;
    @(negedge clk);
    load_req = 1'b0; clr_sel_n = 1'b1;
    chk(req, int'(pos_bus), exp);
    chk(req, int'(busy), 0);
  endtask

  task automatic do_step(input bit up, input int start);
    int exp;
    exp = up ? (start + 1) % M : (start + M - 1) % M;
    @(negedge clk);
    step_valid = 1'b1; rot_up = up;
    @(negedge clk);
    step_valid = 1'b0;
    chk("R4 dir first", int'(dir_out), int'(up));
    chk("R4 no busy yet", int'(busy), 0);
    chk("R4 count held", int'(pos_bus), start);
    @(negedge clk);
    chk("R3 busy", int'(busy), 1);
    chk("R3 count", int'(pos_bus), exp);
    chk("R5 ripple", int'(ripple), int'((up && start == M-1) || (!up && start == 0)));
    @(negedge clk);
    chk("R3 busy one cycle", int'(busy), 0);
    chk("R5 ripple drop", int'(ripple), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; rot_up = 1'b0; step_valid = 1'b0; load_req = 1'b0;
    clr_sel_n = 1'b1; oe_n = 1'b0; load_word = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(pos_bus), 0);
    chk("R1 dir", int'(dir_out), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ripple", int'(ripple), 0);
    rst_n = 1'b1; rot_up = 1'b1;

    // R2 direction toggles without steps
    do_load(6, 1'b0, 6, "R6 plain load");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rot_up = k[0];
      @(negedge clk);
      chk("R2 dir follows", int'(dir_out), int'(k[0]));
      chk("R2 count still", int'(pos_bus), 6);
    end

    // R3 R4 R5 R6: every start value, both senses
    for (int v = 0; v < M; v++) begin
      for (int u = 0; u < 2; u++) begin
        do_load(v, 1'b0, v, "R6 plain load");
        do_step(u[0], v);
      end
    end

    // R7: every count and mask pair
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        do_load(a, 1'b0, a, "R6 plain load");
        do_load(b, 1'b1, a & ~b & (M-1), "R7 masked clear");
      end
    end

    // R8: ready low during load, step before load is dropped
    do_load(3, 1'b0, 3, "R6 plain load");
    @(negedge clk);
    step_valid = 1'b1; rot_up = 1'b1;
    @(negedge clk);
    step_valid = 1'b0;
    load_req = 1'b1; load_word = W'(9);
    #0.5;
    chk("R8 ready low", int'(step_ready), 0);
    @(negedge clk);
    load_req = 1'b0;
    chk("R8 load wins", int'(pos_bus), 9);
    chk("R8 no busy", int'(busy), 0);
    @(negedge clk);
    chk("R8 step dropped", int'(pos_bus), 9);
    chk("R8 still no busy", int'(busy), 0);
    chk("R8 ready back", int'(step_ready), 1);

    // R10: back-to-back steps through wrap
    do_load(14, 1'b0, 14, "R6 plain load");
    @(negedge clk);
    step_valid = 1'b1; rot_up = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k >= 2 && k <= 5) begin
        chk("R10 count", int'(pos_bus), (14 + k - 1) % M);
        chk("R10 busy held", int'(busy), 1);
        chk("R5 ripple streak", int'(ripple), int'(k == 3));
      end
      if (k == 4) step_valid = 1'b0;
      if (k == 6) begin
        chk("R10 final count", int'(pos_bus), 2);
        chk("R10 busy ends", int'(busy), 0);
      end
    end

    // R9: bus float and drive
    oe_n = 1'b1;
    #0.5;
    chk("R9 float", int'(pos_bus === {W{1'bz}}), 1);
    oe_n = 1'b0;
    #0.5;
    chk("R9 drive", int'(pos_bus), 2);

    done = 1'b1;
    finish_up();
  end
endmodule